// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block forms the word a host sees when it reads a memory bank. While the bank runs an embedded program or erase, a read does not return array contents. It returns a status word instead. That word carries a polling bit, two toggle bits, a timeout bit and an erase-window bit. When the bank is idle, the block returns the array word unchanged. The block also drives a ready output that stays low while an embedded operation is in progress.

The embedded algorithm supplies several inputs: a busy level, the operation type, the data bit being programmed, an erase-suspend level, a flag saying whether the current read address lies in the suspended sector, the state of the erase acceptance window, and a timeout flag. Each one-cycle read strobe captures one result word one clock later. The two toggle bits advance once per strobe, so a host that reads twice can tell whether work is still going on. Both toggle bits return to 0 whenever a new embedded operation starts, and an erase resume counts as a new start.

Top module: `pe_status_reporter`

## Requirements
- R1: With the bank neither busy nor suspended, and on a suspended bank read outside the suspended sector, a strobe returns `array_data` unchanged.
- R2: On a strobe during an active program, bit 7 of the word is the complement of `prog_bit`.
- R3: Bit 7 of the status word reads 0 on a strobe during an active erase and 1 on a strobe to the suspended sector.
- R4: During an active operation, bit 6 changes value on every strobe. It does not change on strobes to the suspended sector, which show its held value.
- R5: Bit 2 changes value on every strobe to the suspended sector. During active operation reads it returns its held value unchanged.
- R6: During an active erase, bit 3 reads 0 while `erase_window_open` is 1 and reads 1 once the window is closed. During a program it reads 0.
- R7: Bit 5 equals `op_timeout` during active operation reads and reads 0 on suspended-sector reads.
- R8: `ready` is 1 after reset. It goes to 0 one clock after `op_busy` rises and back to 1 one clock after `op_busy` falls.
- R9: `rd_word` updates one clock after a strobe and is otherwise held. Cycles without a strobe advance neither toggle bit.
- R10: A rising `op_busy` clears both toggle bits to 0. This applies even to a strobe in that same cycle. `rd_word` is 0 after reset.
- R11: All status word bits other than 7, 6, 5, 3 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_busy | input | 1 | Embedded program or erase is running (not suspended) |
| op_is_erase | input | 1 | 1 for erase, 0 for program |
| prog_bit | input | 1 | Data bit 7 being programmed |
| erase_susp | input | 1 | Erase is suspended |
| rd_in_susp_sector | input | 1 | Read address lies in the suspended erase sector |
| erase_window_open | input | 1 | Sector-erase acceptance window still open |
| op_timeout | input | 1 | Operation exceeded its time limit |
| rd_strobe | input | 1 | One-cycle pulse per host read |
| array_data | input | DATA_W | Array read data for pass-through |
| rd_word | output | DATA_W | Captured read result |
| ready | output | 1 | Low while an embedded operation runs |

## Verification
The assertions assume that `op_busy` and `erase_susp` are never high together. They also assume that `rd_strobe` is a single-cycle pulse that is already aligned with its address flags. The bench honours both: it drops `op_busy` in the same cycle that it raises `erase_susp`, and it lowers `erase_susp` before raising `op_busy` on resume. The bench changes every input on the falling edge and pulses the strobe for exactly one cycle. Each read is checked against a bench model of the toggle state, which is cleared at every operation start.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
   typedef enum logic [1:0] {
      RD_PASS   = 2'd0,
      RD_ACTIVE = 2'd1,
      RD_SUSP   = 2'd2
   } rd_mode_e;

   localparam int NUM_TGL = 2;
   localparam int TGL_RUN = 0;
   localparam int TGL_SUS = 1;
endpackage

// File: rtl/pe_mode_dec.sv
module pe_mode_dec
   import pe_status_pkg::*;
(
   input  logic     busy,
   input  logic     susp,
   input  logic     in_susp_sector,
   output rd_mode_e mode
);
   always_comb begin
      if (susp && in_susp_sector)
         mode = RD_SUSP;
      else if (busy && !susp)
         mode = RD_ACTIVE;
      else
         mode = RD_PASS;
   end
endmodule

// File: rtl/pe_tgl_cell.sv
module pe_tgl_cell #(
   parameter logic CLR_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic advance,
   output logic q_eff
);
   logic q;

   assign q_eff = clear ? CLR_VAL : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= CLR_VAL;
      else if (advance)
         q <= ~q_eff;
      else if (clear)
         q <= CLR_VAL;
   end

   AST_TGL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !advance) |=> (q == CLR_VAL)); // R10
   AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear) |=> (q != $past(q))); // R4
   AST_TGL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !clear) |=> $stable(q)); // R9
endmodule

// File: rtl/pe_word_fmt.sv
module pe_word_fmt
   import pe_status_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int POLL_POS = 7,
   parameter int RUN_POS  = 6,
   parameter int TMO_POS  = 5,
   parameter int WIN_POS  = 3,
   parameter int SUS_POS  = 2
) (
   input  rd_mode_e          mode,
   input  logic [DATA_W-1:0] array_data,
   input  logic              is_erase,
   input  logic              prog_bit,
   input  logic              window_open,
   input  logic              timeout,
   input  logic              tgl_run,
   input  logic              tgl_sus,
   output logic [DATA_W-1:0] word
);
   always_comb begin
      word = '0;
      unique case (mode)
         RD_ACTIVE: begin
            word[POLL_POS] = is_erase ? 1'b0 : ~prog_bit;
            word[RUN_POS]  = tgl_run;
            word[TMO_POS]  = timeout;
            word[WIN_POS]  = is_erase & ~window_open;
            word[SUS_POS]  = tgl_sus;
         end
         RD_SUSP: begin
            word[POLL_POS] = 1'b1;
            word[RUN_POS]  = tgl_run;
            word[SUS_POS]  = tgl_sus;
         end
         default: word = array_data;
      endcase
   end
endmodule

// File: rtl/pe_status_reporter.sv
module pe_status_reporter
   import pe_status_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int POLL_POS  = 7,
   parameter int RUN_POS   = 6,
   parameter int TMO_POS   = 5,
   parameter int WIN_POS   = 3,
   parameter int SUS_POS   = 2,
   parameter bit READY_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_busy,
   input  logic              op_is_erase,
   input  logic              prog_bit,
   input  logic              erase_susp,
   input  logic              rd_in_susp_sector,
   input  logic              erase_window_open,
   input  logic              op_timeout,
   input  logic              rd_strobe,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_word,
   output logic              ready
);
   localparam int MAX_POS = DATA_W - 1;

   // elaboration-time parameter checks
   if (DATA_W < 8) begin : g_bad_width
      $error("pe_status_reporter: DATA_W must be at least 8");
   end
   if (POLL_POS > MAX_POS || RUN_POS > MAX_POS || TMO_POS > MAX_POS ||
       WIN_POS > MAX_POS || SUS_POS > MAX_POS) begin : g_bad_pos
      $error("pe_status_reporter: status bit position out of range");
   end
   if (POLL_POS == RUN_POS || POLL_POS == TMO_POS || POLL_POS == WIN_POS ||
       POLL_POS == SUS_POS || RUN_POS == TMO_POS || RUN_POS == WIN_POS ||
       RUN_POS == SUS_POS || TMO_POS == WIN_POS || TMO_POS == SUS_POS ||
       WIN_POS == SUS_POS) begin : g_dup_pos
      $error("pe_status_reporter: status bit positions overlap");
   end

   rd_mode_e          mode;
   logic              busy_q;
   logic              op_start;
   logic [NUM_TGL-1:0] tgl_adv;
   logic [NUM_TGL-1:0] tgl_val;
   logic [DATA_W-1:0] word_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= op_busy;
   end

   assign op_start = op_busy & ~busy_q;

   pe_mode_dec u_mode (
      .busy          (op_busy),
      .susp          (erase_susp),
      .in_susp_sector(rd_in_susp_sector),
      .mode          (mode)
   );

   assign tgl_adv[TGL_RUN] = rd_strobe && (mode == RD_ACTIVE);
   assign tgl_adv[TGL_SUS] = rd_strobe && (mode == RD_SUSP);

   for (genvar gi = 0; gi < NUM_TGL; gi++) begin : g_tgl
      pe_tgl_cell #(.CLR_VAL(1'b0)) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .clear  (op_start),
         .advance(tgl_adv[gi]),
         .q_eff  (tgl_val[gi])
      );
   end

   pe_word_fmt #(
      .DATA_W(DATA_W), .POLL_POS(POLL_POS), .RUN_POS(RUN_POS),
      .TMO_POS(TMO_POS), .WIN_POS(WIN_POS), .SUS_POS(SUS_POS)
   ) u_fmt (
      .mode       (mode),
      .array_data (array_data),
      .is_erase   (op_is_erase),
      .prog_bit   (prog_bit),
      .window_open(erase_window_open),
      .timeout    (op_timeout),
      .tgl_run    (tgl_val[TGL_RUN]),
      .tgl_sus    (tgl_val[TGL_SUS]),
      .word       (word_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rd_word <= '0;
      else if (rd_strobe) rd_word <= word_nxt;
   end

   if (READY_REG) begin : g_ready_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ready <= 1'b1;
         else        ready <= ~op_busy;
      end
      AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         op_busy |=> !ready); // R8
      AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         !op_busy |=> ready); // R8
   end else begin : g_ready_comb
      assign ready = ~op_busy;
   end

   AST_IN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_busy && erase_susp)); // R1
   AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !op_busy && !erase_susp) |=> (rd_word == $past(array_data))); // R1
   AST_POLL_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && op_busy && !op_is_erase) |=> (rd_word[POLL_POS] == !$past(prog_bit))); // R2
   AST_POLL_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && op_busy && op_is_erase) |=> (rd_word[POLL_POS] == 1'b0)); // R3
   AST_WIN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && op_busy && op_is_erase) |=>
         (rd_word[WIN_POS] == !$past(erase_window_open))); // R6
   AST_TMO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && op_busy) |=> (rd_word[TMO_POS] == $past(op_timeout))); // R7
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> $stable(rd_word)); // R9
   AST_START_RUN0: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && op_busy && !busy_q) |=> (rd_word[RUN_POS] == 1'b0)); // R10
endmodule

// File: tb/pe_status_reporter_tb.sv
module pe_status_reporter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_busy = 0, op_is_erase = 0, prog_bit = 0, erase_susp = 0;
   logic        rd_in_susp_sector = 0, erase_window_open = 0, op_timeout = 0;
   logic        rd_strobe = 0;
   logic [15:0] array_data = '0;
   logic [15:0] rd_word;
   logic        ready;

   int n_chk = 0, n_fail = 0;
   logic m_run = 0, m_sus = 0;
   bit   done = 0;

   always #10 clk = ~clk;

   pe_status_reporter u_dut (.*);

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // strobe one read; expected word from the requirement-level model
   task automatic rd_check(string req);
      logic [15:0] e;
      e = '0;
      if (erase_susp && rd_in_susp_sector) begin
         e[7] = 1'b1; e[6] = m_run; e[2] = m_sus;
         m_sus = ~m_sus;
      end else if (op_busy) begin
         e[7] = op_is_erase ? 1'b0 : ~prog_bit;
         e[6] = m_run; e[5] = op_timeout;
         e[3] = op_is_erase & ~erase_window_open; e[2] = m_sus;
         m_run = ~m_run;
      end else
         e = array_data;
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      check(req, rd_word, e);
   endtask

   task automatic start_op(logic erase);
      op_is_erase = erase; erase_susp = 0; op_busy = 1'b1;
      m_run = 0; m_sus = 0;
      @(negedge clk);
      check("R8 ready low", {15'd0, ready}, 16'd0);
   endtask

   task automatic end_op();
      op_busy = 1'b0; op_timeout = 0;
      @(negedge clk);
      check("R8 ready high", {15'd0, ready}, 16'd1);
   endtask

   task automatic t_reset();
      check("R10 reset word", rd_word, 16'h0000);
      check("R8 reset ready", {15'd0, ready}, 16'd1);
   endtask

   task automatic t_pass();
      logic [15:0] held;
      array_data = 16'hA5A5; rd_check("R1 idle pass");
      array_data = 16'h3C96; rd_check("R1 idle pass 2");
      held = rd_word;
      array_data = 16'hFFFF;
      repeat (3) @(negedge clk);
      check("R9 word held", rd_word, held);
   endtask

   task automatic t_program();
      array_data = 16'hFFFF;
      prog_bit = 1'b1; start_op(1'b0);
      rd_check("R2 R4 R11 program read 1");
      rd_check("R4 program read 2");
      rd_check("R4 R6 program read 3");
      prog_bit = 1'b0; rd_check("R2 inverted bit");
      repeat (4) @(negedge clk);
      rd_check("R9 no advance without strobe");
      op_timeout = 1'b1; rd_check("R7 timeout bit");
      end_op();
      array_data = 16'h1234; rd_check("R1 pass after end");
   endtask

   task automatic t_erase_suspend();
      erase_window_open = 1'b1; start_op(1'b1);
      rd_check("R3 R6 erase window open");
      erase_window_open = 1'b0;
      rd_check("R6 erase begun");
      rd_check("R4 erase toggle");
      // suspend: busy drops, suspend rises in the same cycle
      op_busy = 1'b0; erase_susp = 1'b1; rd_in_susp_sector = 1'b1;
      @(negedge clk);
      rd_check("R3 R5 suspended sector 1");
      rd_check("R5 R4 suspended sector 2");
      rd_check("R5 suspended sector 3");
      rd_in_susp_sector = 1'b0; array_data = 16'hBEEF;
      rd_check("R1 other sector in suspend");
      rd_in_susp_sector = 1'b1;
      erase_susp = 1'b0; @(negedge clk);
      start_op(1'b1);
      rd_check("R10 resume clears toggles");
      rd_check("R5 bit2 held in active");
      end_op();
   endtask

   task automatic t_start_same_cycle();
      prog_bit = 1'b1; op_is_erase = 1'b0;
      op_busy = 1'b1; m_run = 0; m_sus = 0;
      rd_check("R10 strobe on start cycle");
      rd_check("R4 after start");
      end_op();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pass();
      t_program();
      t_erase_suspend();
      t_start_same_cycle();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule